// File: doc/BRIEF.md
# Programmable Millisecond Timebase

This block derives two periodic strobes from the system clock. The first stage is a 16-bit reload divider. Software programs its reload value as two bytes. It emits a one-clock `ms_tick` every `(HI*256 + LO + 1)` clocks. The second stage is a 7-bit reload divider that advances once per `ms_tick`. It emits a one-clock `hms_tick` every `(HMS + 1)` millisecond ticks, so its period is `(HI*256 + LO + 1) * (HMS + 1)` clocks.

A small register bus sets the reload values: a write strobe, a 2-bit register select, 8-bit write data and combinational readback. A write to either divider byte is picked up at the next first-stage reload. A write to the second-stage register carries a mode flag in bit 7:
- When the flag is 1, the running second-stage count is replaced straight away.
- When the flag is 0, the new value waits until the current count runs out.

Top module: `ms_timebase`

## Requirements
- R1: After reset the readback values are 0x9F for select 0 (low byte), 0x0F for select 1 (high byte) and 0x63 for select 2 (second-stage register).
- R2: With the reset values, the first `ms_tick` appears 3999 clocks after reset is released, on the cycle the first-stage count reaches zero.
- R3: The first stage repeats every `HI*256 + LO + 1` clocks. Select 0 writes LO and select 1 writes HI. A new byte value takes effect only at the next reload, so the period already running is not shortened.
- R4: `ms_tick` is high for exactly one clock per period.
- R5: The second stage decrements once per `ms_tick`. `hms_tick` is high together with the `ms_tick` on which the second-stage count is zero, and the count then reloads, giving `HMS + 1` millisecond ticks per period.
- R6: A select 2 write with bit 7 = 1 loads bits 6..0 into the second-stage count on the next clock. This replaces any decrement or reload due in that cycle.
- R7: A select 2 write with bit 7 = 0 changes only the stored reload value. The running count finishes and then reloads with the new value.
- R8: Bit 7 of the select 2 readback is always 0. Select 3 reads 0x00, and writes to select 3 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 low byte, 1 high byte, 2 second-stage register, 3 unused |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Readback of the selected register |
| ms_tick | output | 1 | One-clock first-stage strobe |
| hms_tick | output | 1 | One-clock second-stage strobe |

## Verification
The assertions assume that the combined first-stage reload value never drops below 1. A zero reload would make `ms_tick` legitimately high on every clock, and the single-cycle pulse property would then fail. The bench keeps the combined value at 3 or more and starts from the 3999 reset value. All register writes are single-cycle pulses driven between clock edges. The bench also places the immediate-mode and deferred-mode writes at points in the count where the two modes give different `hms_tick` timing.

// File: rtl/mtg_pkg.sv
// Package: shared constants and select encoding for the millisecond timebase.
// Assumes a byte-wide register bus with a 2-bit select.
package mtg_pkg;
    localparam int BYTE_W = 8;
    localparam int SEL_W  = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_LO   = 2'd0,
        SEL_HI   = 2'd1,
        SEL_HMS  = 2'd2,
        SEL_NONE = 2'd3
    } mtg_sel_e;
endpackage

// File: rtl/mtg_regs.sv
// Module: register bank holding the two divider bytes and the second-stage
// reload value. Also flags an immediate second-stage load request.
// Assumes single-cycle write strobes. Bit 7 of the select-2 write data is a
// mode flag and is not stored.
module mtg_regs
    import mtg_pkg::*;
#(
    parameter logic [BYTE_W-1:0] LO_RST  = 8'h9F,
    parameter logic [BYTE_W-1:0] HI_RST  = 8'h0F,
    parameter int                HMS_W   = 7,
    parameter logic [HMS_W-1:0]  HMS_RST = 7'h63
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [SEL_W-1:0]    reg_sel,
    input  logic [BYTE_W-1:0]   wr_data,
    output logic [BYTE_W-1:0]   rd_data,
    output logic [2*BYTE_W-1:0] div_reload,
    output logic [HMS_W-1:0]    hms_reload,
    output logic                hms_load_now
);
    localparam int PAD_W = BYTE_W - HMS_W;

    logic [BYTE_W-1:0] lo_q, hi_q;
    logic [HMS_W-1:0]  hms_q;

    // Store the written byte in the selected register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q  <= LO_RST;
            hi_q  <= HI_RST;
            hms_q <= HMS_RST;
        end else if (wr_en) begin
            case (mtg_sel_e'(reg_sel))
                SEL_LO:  lo_q  <= wr_data;
                SEL_HI:  hi_q  <= wr_data;
                SEL_HMS: hms_q <= wr_data[HMS_W-1:0];
                default: ;
            endcase
        end
    end

    // Readback mux; the mode flag position always reads as zero.
    always_comb begin
        case (mtg_sel_e'(reg_sel))
            SEL_LO:  rd_data = lo_q;
            SEL_HI:  rd_data = hi_q;
            SEL_HMS: rd_data = {{PAD_W{1'b0}}, hms_q};
            default: rd_data = '0;
        endcase
    end

    // Immediate-load request: a select-2 write with the top data bit set.
    assign hms_load_now = wr_en && (mtg_sel_e'(reg_sel) == SEL_HMS) && wr_data[BYTE_W-1];
    assign div_reload   = {hi_q, lo_q};
    assign hms_reload   = hms_q;
endmodule

// File: rtl/mtg_div_stage1.sv
// Module: first-stage reload divider. It counts down from the reload value
// and strobes while the count is zero, then reloads, so the period is
// reload + 1 clocks.
// Assumes reload is at least 1 when single-cycle pulses are needed.
module mtg_div_stage1 #(
    parameter int                CNT_W = 16,
    parameter logic [CNT_W-1:0]  CNT_RST = 16'h0F9F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             tick
);
    // Count down; pick up the current reload value at terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n)       count <= CNT_RST;
        else if (tick)    count <= reload;
        else              count <= count - 1'b1;
    end

    // Strobe on the terminal state.
    assign tick = (count == '0);
endmodule

// File: rtl/mtg_div_stage2.sv
// Module: second-stage reload divider. It advances once per first-stage
// strobe and strobes when a first-stage strobe meets a zero count. An
// immediate load request overrides the step due in the same cycle.
// Assumes advance is a one-cycle strobe.
module mtg_div_stage2 #(
    parameter int               CNT_W = 7,
    parameter logic [CNT_W-1:0] CNT_RST = 7'h63
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic [CNT_W-1:0] reload,
    input  logic             load_now,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             tick
);
    // Immediate load first, else reload at expiry, else decrement on advance.
    always_ff @(posedge clk) begin
        if (!rst_n)         count <= CNT_RST;
        else if (load_now)  count <= load_val;
        else if (tick)      count <= reload;
        else if (advance)   count <= count - 1'b1;
    end

    // Strobe when an advance finds the count exhausted.
    assign tick = advance && (count == '0);
endmodule

// File: rtl/ms_timebase.sv
// Module: top of the two-stage millisecond timebase. It joins the register
// bank to the two dividers.
// Assumes a synchronous active-low reset and a byte-wide register bus.
module ms_timebase
    import mtg_pkg::*;
#(
    parameter logic [BYTE_W-1:0] LO_RST  = 8'h9F,
    parameter logic [BYTE_W-1:0] HI_RST  = 8'h0F,
    parameter int                HMS_W   = 7,
    parameter logic [HMS_W-1:0]  HMS_RST = 7'h63
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        reg_sel,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    output logic              ms_tick,
    output logic              hms_tick
);
    localparam int DIV_W = 2 * BYTE_W;

    logic [DIV_W-1:0] div_reload;
    logic [DIV_W-1:0] div_count;
    logic [HMS_W-1:0] hms_reload;
    logic [HMS_W-1:0] hms_count;
    logic             hms_load_now;

    mtg_regs #(
        .LO_RST(LO_RST), .HI_RST(HI_RST), .HMS_W(HMS_W), .HMS_RST(HMS_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel),
        .wr_data(wr_data), .rd_data(rd_data), .div_reload(div_reload),
        .hms_reload(hms_reload), .hms_load_now(hms_load_now)
    );

    mtg_div_stage1 #(
        .CNT_W(DIV_W), .CNT_RST({HI_RST, LO_RST})
    ) u_stage1 (
        .clk(clk), .rst_n(rst_n), .reload(div_reload),
        .count(div_count), .tick(ms_tick)
    );

    mtg_div_stage2 #(
        .CNT_W(HMS_W), .CNT_RST(HMS_RST)
    ) u_stage2 (
        .clk(clk), .rst_n(rst_n), .advance(ms_tick), .reload(hms_reload),
        .load_now(hms_load_now), .load_val(wr_data[HMS_W-1:0]),
        .count(hms_count), .tick(hms_tick)
    );
endmodule

// File: rtl/ms_timebase_chk.sv
// Module: property checker for ms_timebase, attached with bind.
// Assumes the combined first-stage reload value is never below 1.
module ms_timebase_chk #(
    parameter int DIV_W = 16,
    parameter int HMS_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       reg_sel,
    input logic [7:0]       wr_data,
    input logic             ms_tick,
    input logic             hms_tick,
    input logic [DIV_W-1:0] div_count,
    input logic [DIV_W-1:0] div_reload,
    input logic [HMS_W-1:0] hms_count
);
    // R3: the terminal count reloads from the programmed bytes.
    a_r3_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
        ms_tick |=> (div_count == $past(div_reload)));

    // R3: between reloads the first stage steps down by one.
    a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        !ms_tick |=> (div_count == $past(div_count) - 1'b1));

    // R4: the millisecond strobe lasts one clock.
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ms_tick |=> !ms_tick);

    // R5: a hundred-ms strobe only coincides with a millisecond strobe.
    a_r5_hms_on_ms: assert property (@(posedge clk) disable iff (!rst_n)
        hms_tick |-> ms_tick);

    // R6: an immediate-mode write lands in the running count.
    a_r6_immediate_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == 2'd2 && wr_data[7]) |=> (hms_count == $past(wr_data[HMS_W-1:0])));

    // R5: without a write, the second stage holds between millisecond strobes.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ms_tick && !(wr_en && reg_sel == 2'd2)) |=> $stable(hms_count));
endmodule

bind ms_timebase ms_timebase_chk #(.DIV_W(DIV_W), .HMS_W(HMS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel),
    .wr_data(wr_data), .ms_tick(ms_tick), .hms_tick(hms_tick),
    .div_count(div_count), .div_reload(div_reload), .hms_count(hms_count)
);

// File: tb/ms_timebase_tb_top.sv
// Bench: scoreboard. The driver pushes the expected strobe cycles into queues
// and the monitor pops and compares them as the strobes appear.
module ms_timebase_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int END_CYC    = 4120;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       ms_tick, hms_tick;

    int cyc = 0;
    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;
    int ms_q[$];
    int hms_q[$];

    ms_timebase dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel),
        .wr_data(wr_data), .rd_data(rd_data), .ms_tick(ms_tick), .hms_tick(hms_tick)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Count clock edges seen since reset release.
    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic wait_cyc(input int c);
        while (cyc != c) @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] s, input logic [7:0] d);
        reg_sel = s; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] s, input int exp, input string req);
        reg_sel = s;
        #1;
        check(req, rd_data, exp);
    endtask

    // Monitor: each strobe is compared against the front of its queue.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (ms_tick) begin
                if (ms_q.size() == 0) check("R4 extra ms_tick", cyc, -1);
                else check("R3 ms_tick cycle", cyc, ms_q.pop_front());
            end else if (ms_q.size() != 0 && ms_q[0] < cyc) begin
                check("R3 missed ms_tick", -1, ms_q.pop_front());
            end
            if (hms_tick) begin
                if (hms_q.size() == 0) check("R5 extra hms_tick", cyc, -1);
                else check("R5 hms_tick cycle", cyc, hms_q.pop_front());
            end else if (hms_q.size() != 0 && hms_q[0] < cyc) begin
                check("R5 missed hms_tick", -1, hms_q.pop_front());
            end
        end
    end

    // Driver: reset, programming sequence and expected strobe cycles.
    initial begin
        // R2 first strobe at 3999; R3 period 4 after the low write, 8 after the second.
        ms_q.push_back(3999);
        for (int t = 4003; t <= 4075; t += 4) ms_q.push_back(t);
        for (int t = 4083; t <= 4115; t += 8) ms_q.push_back(t);
        // R6/R7 expected second-stage strobes for the writes below.
        hms_q.push_back(4007); hms_q.push_back(4019); hms_q.push_back(4031);
        hms_q.push_back(4039); hms_q.push_back(4047); hms_q.push_back(4071);
        hms_q.push_back(4115);

        repeat (3) @(negedge clk);
        reg_read(2'd0, 8'h9F, "R1 low reset");
        reg_read(2'd1, 8'h0F, "R1 high reset");
        reg_read(2'd2, 8'h63, "R1 hms reset");
        check("R2 no ms_tick in reset", ms_tick, 0);
        rst_n = 1'b1;

        wait_cyc(10); reg_write(2'd0, 8'h03);   // R3 low byte 3
        reg_write(2'd1, 8'h00);                  // R3 high byte 0
        reg_write(2'd2, 8'h82);                  // R6 immediate load of 2
        reg_read(2'd2, 8'h02, "R8 flag reads 0");
        reg_write(2'd3, 8'hFF);                  // R8 write to unused select
        reg_read(2'd3, 8'h00, "R8 unused reads 0");
        reg_read(2'd0, 8'h03, "R8 low unchanged");
        reg_read(2'd1, 8'h00, "R8 high unchanged");
        reg_read(2'd2, 8'h02, "R8 hms unchanged");

        wait_cyc(4021); reg_write(2'd2, 8'h01);  // R7 deferred load of 1
        reg_read(2'd2, 8'h01, "R7 stored value");
        wait_cyc(4049); reg_write(2'd2, 8'h85);  // R6 immediate load of 5
        reg_read(2'd2, 8'h05, "R8 flag reads 0 again");
        wait_cyc(4073); reg_write(2'd0, 8'h07);  // R3 deferred low change

        wait_cyc(END_CYC);
        done = 1'b1;
        check("R3 pending ms strobes", ms_q.size(), 0);
        check("R5 pending hms strobes", hms_q.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * 200000);
        done = 1'b1;
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish by cycle %0d", END_CYC);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule